// File: doc/BRIEF.md
# Status-Framed Serial Angle Shifter

This block is the serial output path of an angle-measurement device. On each read it takes a 12-bit angle or velocity word, a tag that says which of the two it is, and two fault flags: a degraded-signal flag and a lost-tracking flag. It packs them into a 16-bit frame that ends in a parity bit, so that the full word always carries an odd number of ones. The frame is then shifted out most significant bit first on a single data line, driven by a serial clock from the host.

The host's read strobe, which is active low, acts as both the frame sync and the output enable. When it falls while the chip select is low, the block loads a fresh frame and puts its top bit on the line at once. Each later rising edge of the serial clock moves the next bit onto the line, where the host captures it on the following falling edge. Once all 16 bits are out, further clocks shift out zeros.

The host's strobe, clock and chip select are asynchronous to the block. They are oversampled in a system clock that must run at least four times faster than the serial clock. Each one passes through a two-flop synchroniser before any edge is detected.

Top module: `serial_angle_shifter`

## Requirements
- R1: The frame is ordered as follows. Bits 15..4 hold `word_in` with its MSB at bit 15. Bit 3 holds `pos_tag` (1 = position, 0 = velocity). Bit 2 holds `deg_flag` and bit 1 holds `trk_lost`.
- R2: Frame bit 0 is set so that the 16-bit frame always holds an odd number of ones.
- R3: A falling edge of `rd_n` while `cs_n` is low loads the frame. Bit 15 appears on `so_data` three system clocks after the `rd_n` change, with no serial clock edge needed.
- R4: While `rd_n` stays low, each rising edge of `sclk` moves the next lower frame bit onto `so_data`. After 15 such edges, `so_data` shows bit 0.
- R5: Rising edges of `sclk` after bit 0 has been shown make `so_data` low for as long as `rd_n` stays low.
- R6: `so_oe` is low while `rd_n` is high or `cs_n` is high, after the same three-clock latency.
- R7: If an `sclk` rising edge and the `rd_n` falling edge reach the edge detectors in the same system clock, the load takes priority. Bit 15 is not skipped, and the next `sclk` rise shows bit 14.
- R8: After a synchronous reset (`rst_n` low at a clock edge), `so_oe` and `so_data` are low.
- R9: A new `rd_n` falling edge restarts the frame from bit 15 with the current inputs, even if the previous frame was left partly shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| rd_n | input | 1 | Frame sync and output enable, active low (asynchronous) |
| cs_n | input | 1 | Chip select, active low (asynchronous) |
| word_in | input | 12 | Angle or velocity word to send |
| pos_tag | input | 1 | 1 = word is a position, 0 = word is a velocity |
| deg_flag | input | 1 | Degraded-signal fault flag |
| trk_lost | input | 1 | Loss-of-tracking fault flag |
| so_data | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so_data` pad driver |

## Verification
The assertions assume the following about the inputs:
- Each level of `sclk` lasts at least two system clocks, so the synchroniser sees every edge.
- `word_in` and the flags are stable on the clock in which a load takes place.

The bench keeps to these assumptions:
- It holds each `sclk` phase for four system clocks.
- It changes every input on the falling system-clock edge.
- It changes the word and flags only while `rd_n` is high.
- It waits four clocks after each input change before it samples, which covers the three-register path.

// File: rtl/sas_pkg.sv
// Package: shared widths and the frame type of the serial angle shifter.
// Assumes: a 16-bit frame made of a data field followed by four status bits.
package sas_pkg;
    localparam int DATA_W  = 12;
    localparam int STAT_W  = 4;
    localparam int FRAME_W = DATA_W + STAT_W;
    localparam int SYNC_STAGES = 2;

    typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/sas_sync.sv
// Module: multi-stage synchroniser for one asynchronous level.
// Assumes: the input holds each level for longer than STAGES system clocks.
//          IDLE is the reset value and matches the line's idle level.
module sas_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Move the level through the flop chain one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{IDLE}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sas_frame_pack.sv
// Module: builds the output frame from the word, the tag, the two flags and odd parity.
// Assumes: the inputs are stable on the clock in which the shifter loads.
module sas_frame_pack
    import sas_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] word,
    input  logic          tag,
    input  logic          deg,
    input  logic          lost,
    output frame_t        frame
);
    logic [DW+2:0] body;

    // Put the data word and the three status bits together, then add the parity bit.
    always_comb begin
        body  = {word, tag, deg, lost};
        frame = {body, ~(^body)};
    end

    // R2: the frame always carries an odd number of ones.
    p_odd_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(frame) % 2) == 1));
endmodule

// File: rtl/sas_shifter.sv
// Module: frame shift register plus a registered output enable.
// Assumes: load and shift are one-clock pulses; when both are high, load wins.
module sas_shifter
    import sas_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   shift,
    input  logic   oe_next,
    input  frame_t frame,
    output logic   so_bit,
    output logic   so_en
);
    frame_t shreg;

    // Load a new frame, or shift left and fill from below with zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)     shreg <= '0;
        else if (load)  shreg <= frame;
        else if (shift) shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end

    // Register the output enable so that it changes on the same edge as the data.
    always_ff @(posedge clk) begin
        if (!rst_n) so_en <= 1'b0;
        else        so_en <= oe_next;
    end

    assign so_bit = shreg[FRAME_W-1];

    // R3: a load puts the new frame's top bit on the output.
    p_load_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (so_bit == $past(frame[FRAME_W-1])));
    // R4: a shift brings the next lower bit to the top.
    p_shift_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (so_bit == $past(shreg[FRAME_W-2])));
    // R5: an emptied register stays zero until the next load.
    p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((shreg == '0) && !load) |=> (shreg == '0));
endmodule

// File: rtl/serial_angle_shifter.sv
// Module: top of the serial angle shifter. It synchronises the host strobes,
// detects the edges of rd_n and sclk, and drives the frame packer and the shifter.
// Assumes: clk runs at least 4x the sclk rate, and each sclk level lasts 2 or more clocks.
module serial_angle_shifter
    import sas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              rd_n,
    input  logic              cs_n,
    input  logic [DATA_W-1:0] word_in,
    input  logic              pos_tag,
    input  logic              deg_flag,
    input  logic              trk_lost,
    output logic              so_data,
    output logic              so_oe
);
    localparam int          NSYNC = 3;
    localparam logic [NSYNC-1:0] IDLE_LVL = 3'b111;   // cs_n, rd_n and sclk all idle high

    logic [NSYNC-1:0] raw_in, sync_lvl;
    logic sclk_s, rd_s, cs_s;
    logic sclk_q, rd_q;
    logic rd_fall, sclk_rise, load, shift, oe_next;
    frame_t frame;

    assign raw_in = {cs_n, rd_n, sclk};

    genvar gi;
    generate
        for (gi = 0; gi < NSYNC; gi++) begin : g_sync
            sas_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE_LVL[gi])) u_sync (
                .clk(clk), .rst_n(rst_n), .din(raw_in[gi]), .dout(sync_lvl[gi])
            );
        end
    endgenerate

    assign {cs_s, rd_s, sclk_s} = sync_lvl;

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            rd_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            rd_q   <= rd_s;
        end
    end

    // Turn the edges into load, shift and output-enable controls.
    always_comb begin
        rd_fall   = rd_q & ~rd_s;
        sclk_rise = ~sclk_q & sclk_s;
        load      = rd_fall & ~cs_s;
        shift     = sclk_rise & ~rd_s;
        oe_next   = ~rd_s & ~cs_s;
    end

    sas_frame_pack #(.DW(DATA_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .word(word_in), .tag(pos_tag),
        .deg(deg_flag), .lost(trk_lost), .frame(frame)
    );

    sas_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .oe_next(oe_next), .frame(frame), .so_bit(so_data), .so_en(so_oe)
    );

    // R6: the output is disabled one clock after the synchronised rd_n or cs_n is high.
    p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s || cs_s) |=> !so_oe);
    // R7: when both edges coincide, the load wins and bit 15 is kept.
    p_coincide_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall && sclk_rise && !cs_s) |=> (so_data == $past(frame[FRAME_W-1])));
    // R8: the output stays disabled for the clock after a reset.
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> !so_oe);
endmodule

// File: tb/tb_serial_angle_shifter.sv
module tb_serial_angle_shifter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, rd_n = 1'b1, cs_n = 1'b0;
    logic [11:0] word_in = '0;
    logic pos_tag = 1'b0, deg_flag = 1'b0, trk_lost = 1'b0;
    logic so_data, so_oe;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    serial_angle_shifter dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .rd_n(rd_n), .cs_n(cs_n),
        .word_in(word_in), .pos_tag(pos_tag), .deg_flag(deg_flag),
        .trk_lost(trk_lost), .so_data(so_data), .so_oe(so_oe)
    );

    // {word[31:20], tag[19], deg[18], lost[17], spare[16], expected frame[15:0]}
    localparam logic [31:0] VEC [5] = '{
        {12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001},
        {12'hFFF, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFE},
        {12'hA5C, 1'b1, 1'b0, 1'b0, 1'b0, 16'hA5C8},
        {12'h801, 1'b0, 1'b1, 1'b0, 1'b0, 16'h8014},
        {12'h7FF, 1'b0, 1'b0, 1'b1, 1'b0, 16'h7FF3}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic sclk_pulse();
        sclk = 1'b0; tick(4);
        sclk = 1'b1; tick(4);
    endtask

    // Read one whole frame. coincide=1 makes rd_n fall together with an sclk rise.
    task automatic read_frame(input logic [15:0] exp, input bit coincide);
        logic [15:0] rx;
        if (coincide) begin
            sclk = 1'b0; tick(4);
            rd_n = 1'b0; sclk = 1'b1; tick(4);
            chk("R7 top bit kept", {15'd0, so_data}, {15'd0, exp[15]});
        end else begin
            rd_n = 1'b0; tick(4);
            chk("R3 top bit on rd fall", {15'd0, so_data}, {15'd0, exp[15]});
        end
        chk("R6 oe on", {15'd0, so_oe}, 16'd1);
        rx[15] = so_data;
        for (int i = 14; i >= 0; i--) begin
            sclk_pulse();
            rx[i] = so_data;
            if (so_data !== exp[i]) chk("R4 bit", {15'd0, so_data}, {15'd0, exp[i]});
        end
        chk("R1 R2 R4 frame", rx, exp);
        sclk_pulse();
        chk("R5 zero after bit 0", {15'd0, so_data}, 16'd0);
        sclk_pulse();
        chk("R5 zero again", {15'd0, so_data}, 16'd0);
        rd_n = 1'b1; tick(4);
        chk("R6 oe off with rd high", {15'd0, so_oe}, 16'd0);
    endtask

    task automatic apply(input int k);
        {word_in, pos_tag, deg_flag, trk_lost} = VEC[k][31:17];
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(5);
        chk("R8 oe low in reset", {15'd0, so_oe}, 16'd0);
        chk("R8 data low in reset", {15'd0, so_data}, 16'd0);
        rst_n = 1'b1; tick(4);
        chk("R8 oe low after reset", {15'd0, so_oe}, 16'd0);

        // Walk the vector table.
        for (int k = 0; k < 5; k++) begin
            apply(k); tick(2);
            read_frame(VEC[k][15:0], 1'b0);
        end

        // R7: rd_n falls together with an sclk rise.
        apply(2); tick(2);
        read_frame(VEC[2][15:0], 1'b1);

        // R6: cs_n high keeps the output disabled during a read.
        apply(1); cs_n = 1'b1; tick(4);
        rd_n = 1'b0; tick(4);
        chk("R6 oe off with cs high", {15'd0, so_oe}, 16'd0);
        sclk_pulse();
        chk("R6 oe still off", {15'd0, so_oe}, 16'd0);
        rd_n = 1'b1; tick(4);
        cs_n = 1'b0; tick(4);

        // R9: abort mid-frame, then restart with new inputs.
        apply(3); tick(2);
        rd_n = 1'b0; tick(4);
        repeat (5) sclk_pulse();
        rd_n = 1'b1; tick(4);
        apply(4); tick(2);
        rd_n = 1'b0; tick(4);
        chk("R9 restart top bit", {15'd0, so_data}, {15'd0, VEC[4][15]});
        sclk_pulse();
        chk("R9 restart bit 14", {15'd0, so_data}, {15'd0, VEC[4][14]});
        rd_n = 1'b1; tick(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule